// File: doc/BRIEF.md
# Slot-Based Multi-Engine Memory Read Scheduler

This block lets several streaming compute engines share one external memory read port. A fixed schedule, set before the run, controls how the port is shared. Time on the port is cut into slots. A slot is exactly one burst, and every burst has the same fixed length. During a slot the port belongs to a single engine.

Engines take their turns in index order and wrap around at the end. In one turn an engine may hold several back-to-back slots. Its share of the bandwidth is therefore its slot count divided by the sum of all slot counts in a round.

Each engine runs a list of subgraphs. A configuration table holds one entry per subgraph of each engine. An entry gives:
- the slots granted per turn,
- the transfer size in port words,
- the base word address.

A per-engine subgraph register selects the active entry. That register steps to the next subgraph once the current transfer is finished.

Words that come back from memory are routed to a FIFO owned by the granted engine. The FIFO lets the engine consume a steady stream instead of bursts.

An engine is skipped, and its turn passes to the next engine, in two cases:
- it has finished all its subgraphs;
- its FIFO cannot take a whole burst.

A start pulse launches a run. A done flag reports that every engine has finished.

Top module: `slot_mem_sched`

## Requirements
- R1: While reset is asserted and before the first start pulse, the outputs req_valid, done and every bit of out_valid stay 0.
- R2: Every request has a length of BURST words. The exception is the last request of a subgraph, which carries the remaining word count (from 1 to BURST).
- R3: The first request of a subgraph uses the base address of that subgraph. Each later request of the same subgraph starts where the previous request ended (previous address plus previous length, in words).
- R4: Engine turns follow index order 0, 1, ... NUM_ENG-1 and then wrap. In one turn an engine is granted at most the slot count of its active subgraph, as consecutive requests. Its turn then ends.
- R5: When a subgraph's transfer completes, the engine's turn ends at once. Its next request comes from its next subgraph, table entry index engine*NUM_SG + subgraph.
- R6: An engine that has finished all of its subgraphs receives no further requests. After every engine has finished, no request is issued until the next start pulse.
- R7: An engine whose FIFO holds more than DEPTH-BURST words is skipped and receives no request. It becomes eligible again once its FIFO has drained to DEPTH-BURST words or fewer.
- R8: Each word returned on rd_data goes to the FIFO of the engine that owns the slot. Each engine's out_data stream is exactly the memory words of its own requests, in request order and address order.
- R9: done rises after the last word of the last transfer has been received and all engines have finished. It stays high with no requests until a start pulse, which clears it and restarts every engine at subgraph 0.
- R10: Only one request is outstanding at a time. While req_valid is high and req_ready is low, req_addr and req_len hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset. Released synchronously inside the block. |
| start | input | 1 | Pulse that begins a run. Honoured only while idle. |
| cfg_slots | input | NUM_ENG*NUM_SG*SLOT_W | Slots per turn for each table entry. Entry index is engine*NUM_SG + subgraph. Each value must be 1 or more. |
| cfg_size | input | NUM_ENG*NUM_SG*SIZE_W | Transfer size of each entry, in port words. Each value must be 1 or more. |
| cfg_base | input | NUM_ENG*NUM_SG*ADDR_W | Base word address of each entry |
| req_valid | output | 1 | Burst read request valid |
| req_ready | input | 1 | Memory accepts the request |
| req_addr | output | ADDR_W | Start word address of the burst |
| req_len | output | LEN_W | Burst length in words, from 1 to BURST |
| rd_valid | input | 1 | Read data word valid |
| rd_data | input | DATA_W | Read data word |
| out_valid | output | NUM_ENG | Per-engine FIFO has a word |
| out_ready | input | NUM_ENG | Per-engine consumer takes the word |
| out_data | output | NUM_ENG*DATA_W | Per-engine FIFO head word. Engine e occupies bits e*DATA_W upward. |
| done | output | 1 | All engines finished |

## Verification
Two pairs of functions can fall in the same cycle.

The first pair is a subgraph's truncated final burst finishing in the very slot where the engine's slot count also runs out. Both events end the turn, and the subgraph must advance exactly once. Uneven sizes and slot counts provoke this. The bench's behavioural model judges it by the address, the length and the owning engine of every accepted request.

The second pair is a FIFO push landing in the same cycle as a consumer pop. A stalled consumer then provokes the skip of a full FIFO. Its later release provokes resumption. This is judged by the absence of requests to the stalled engine while its FIFO is full, and by the exact word order on every out_data stream.

// File: rtl/sms_pkg.sv
package sms_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_PICK = 2'd1,
    ST_REQ  = 2'd2,
    ST_DATA = 2'd3
  } sms_state_t;
endpackage

// File: rtl/sms_fifo.sv
module sms_fifo #(
  parameter int DATA_W = 64,
  parameter int DEPTH  = 8,
  parameter int BURST  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push_i,
  input  logic [DATA_W-1:0] din_i,
  input  logic              ready_i,
  output logic              valid_o,
  output logic [DATA_W-1:0] dout_o,
  output logic              room_o
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = AW + 1;

  logic [DATA_W-1:0] mem_q [DEPTH];
  logic [AW-1:0]     wp_q, wp_d, rp_q, rp_d;
  logic [CW-1:0]     cnt_q, cnt_d;
  logic              wr_en, rd_en;

  assign valid_o = (cnt_q != '0);
  assign rd_en   = valid_o & ready_i;
  assign wr_en   = push_i & (cnt_q != CW'(DEPTH));
  assign room_o  = (int'(cnt_q) <= DEPTH - BURST);
  assign dout_o  = mem_q[rp_q];

  always_comb begin
    wp_d  = wp_q;
    rp_d  = rp_q;
    cnt_d = cnt_q;
    if (wr_en) wp_d = (int'(wp_q) == DEPTH - 1) ? '0 : wp_q + 1'b1;
    if (rd_en) rp_d = (int'(rp_q) == DEPTH - 1) ? '0 : rp_q + 1'b1;
    if (wr_en && !rd_en) cnt_d = cnt_q + 1'b1;
    else if (rd_en && !wr_en) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      wp_q  <= wp_d;
      rp_q  <= rp_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) mem_q[wp_q] <= din_i;
  end

  // R7
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push_i |-> (cnt_q != CW'(DEPTH)));
endmodule

// File: rtl/sms_tbl.sv
module sms_tbl #(
  parameter int NUM_ENG = 3,
  parameter int NUM_SG  = 2,
  parameter int SLOT_W  = 4,
  parameter int SIZE_W  = 16,
  parameter int ADDR_W  = 16,
  parameter int ENG_W   = 2,
  parameter int SGI_W   = 2
) (
  input  logic [NUM_ENG*NUM_SG-1:0][SLOT_W-1:0] cfg_slots,
  input  logic [NUM_ENG*NUM_SG-1:0][SIZE_W-1:0] cfg_size,
  input  logic [NUM_ENG*NUM_SG-1:0][ADDR_W-1:0] cfg_base,
  input  logic [ENG_W-1:0]                      eng_i,
  input  logic [SGI_W-1:0]                      sg_i,
  output logic [SLOT_W-1:0]                     cur_slots_o,
  output logic [SIZE_W-1:0]                     nxt_size_o,
  output logic [ADDR_W-1:0]                     nxt_base_o,
  output logic                                  has_next_o
);
  always_comb begin
    int ei, si, ci, ni;
    ei = (int'(eng_i) < NUM_ENG) ? int'(eng_i) : 0;
    si = (int'(sg_i) < NUM_SG) ? int'(sg_i) : NUM_SG - 1;
    ci = ei * NUM_SG + si;
    has_next_o  = (int'(sg_i) + 1 < NUM_SG);
    ni = has_next_o ? ci + 1 : ci;
    cur_slots_o = cfg_slots[ci];
    nxt_size_o  = cfg_size[ni];
    nxt_base_o  = cfg_base[ni];
  end
endmodule

// File: rtl/sms_ctrl.sv
module sms_ctrl
  import sms_pkg::*;
#(
  parameter int NUM_ENG = 3,
  parameter int NUM_SG  = 2,
  parameter int BURST   = 4,
  parameter int SLOT_W  = 4,
  parameter int SIZE_W  = 16,
  parameter int ADDR_W  = 16,
  parameter int LEN_W   = 3
) (
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic                                  start,
  input  logic [NUM_ENG*NUM_SG-1:0][SLOT_W-1:0] cfg_slots,
  input  logic [NUM_ENG*NUM_SG-1:0][SIZE_W-1:0] cfg_size,
  input  logic [NUM_ENG*NUM_SG-1:0][ADDR_W-1:0] cfg_base,
  input  logic [NUM_ENG-1:0]                    room_i,
  output logic                                  req_valid,
  input  logic                                  req_ready,
  output logic [ADDR_W-1:0]                     req_addr,
  output logic [LEN_W-1:0]                      req_len,
  input  logic                                  rd_valid,
  output logic [NUM_ENG-1:0]                    push_o,
  output logic                                  done
);
  localparam int ENG_W = (NUM_ENG > 1) ? $clog2(NUM_ENG) : 1;
  localparam int SGI_W = $clog2(NUM_SG + 1);

  sms_state_t      st_q, st_d;
  logic [ENG_W-1:0]  eng_q, eng_d, eng_nxt;
  logic [SLOT_W-1:0] used_q, used_d;
  logic [LEN_W-1:0]  len_q, len_d, beat_q, beat_d;
  logic              done_q, done_d;
  logic [SGI_W-1:0]  sg_q   [NUM_ENG];
  logic [SGI_W-1:0]  sg_d   [NUM_ENG];
  logic [SIZE_W-1:0] rem_q  [NUM_ENG];
  logic [SIZE_W-1:0] rem_d  [NUM_ENG];
  logic [ADDR_W-1:0] ptr_q  [NUM_ENG];
  logic [ADDR_W-1:0] ptr_d  [NUM_ENG];
  logic [NUM_ENG-1:0] fin;
  logic [SGI_W-1:0]  cur_sg;
  logic [SIZE_W-1:0] cur_rem;
  logic [SLOT_W-1:0] t_slots;
  logic [SIZE_W-1:0] t_size;
  logic [ADDR_W-1:0] t_base;
  logic              t_next;

  sms_tbl #(
    .NUM_ENG(NUM_ENG), .NUM_SG(NUM_SG), .SLOT_W(SLOT_W), .SIZE_W(SIZE_W),
    .ADDR_W(ADDR_W), .ENG_W(ENG_W), .SGI_W(SGI_W)
  ) i_tbl (
    .cfg_slots(cfg_slots), .cfg_size(cfg_size), .cfg_base(cfg_base),
    .eng_i(eng_q), .sg_i(cur_sg), .cur_slots_o(t_slots),
    .nxt_size_o(t_size), .nxt_base_o(t_base), .has_next_o(t_next)
  );

  genvar g;
  generate
    for (g = 0; g < NUM_ENG; g++) begin : g_eng
      assign fin[g]    = (int'(sg_q[g]) == NUM_SG);
      assign push_o[g] = (st_q == ST_DATA) && rd_valid && (int'(eng_q) == g);
    end
  endgenerate

  assign cur_sg    = sg_q[eng_q];
  assign cur_rem   = rem_q[eng_q];
  assign eng_nxt   = (int'(eng_q) == NUM_ENG - 1) ? '0 : eng_q + 1'b1;
  assign req_valid = (st_q == ST_REQ);
  assign req_addr  = ptr_q[eng_q];
  assign req_len   = len_q;
  assign done      = done_q;

  always_comb begin
    st_d   = st_q;
    eng_d  = eng_q;
    used_d = used_q;
    len_d  = len_q;
    beat_d = beat_q;
    done_d = done_q;
    sg_d   = sg_q;
    rem_d  = rem_q;
    ptr_d  = ptr_q;
    case (st_q)
      ST_IDLE: begin
        if (start) begin
          for (int e = 0; e < NUM_ENG; e++) begin
            sg_d[e]  = '0;
            rem_d[e] = cfg_size[e*NUM_SG];
            ptr_d[e] = cfg_base[e*NUM_SG];
          end
          eng_d  = '0;
          used_d = '0;
          done_d = 1'b0;
          st_d   = ST_PICK;
        end
      end
      ST_PICK: begin
        if (&fin) begin
          done_d = 1'b1;
          st_d   = ST_IDLE;
        end else if (!fin[eng_q] && room_i[eng_q]) begin
          len_d = (int'(cur_rem) < BURST) ? LEN_W'(cur_rem) : LEN_W'(BURST);
          st_d  = ST_REQ;
        end else begin
          eng_d  = eng_nxt;
          used_d = '0;
        end
      end
      ST_REQ: begin
        if (req_ready) begin
          beat_d = '0;
          st_d   = ST_DATA;
        end
      end
      default: begin
        if (rd_valid) begin
          beat_d = beat_q + 1'b1;
          if (beat_q == len_q - 1'b1) begin
            st_d          = ST_PICK;
            ptr_d[eng_q]  = ptr_q[eng_q] + ADDR_W'(len_q);
            rem_d[eng_q]  = cur_rem - SIZE_W'(len_q);
            if (cur_rem == SIZE_W'(len_q)) begin
              sg_d[eng_q] = cur_sg + 1'b1;
              if (t_next) begin
                rem_d[eng_q] = t_size;
                ptr_d[eng_q] = t_base;
              end
              eng_d  = eng_nxt;
              used_d = '0;
            end else if (used_q + 1'b1 == t_slots) begin
              eng_d  = eng_nxt;
              used_d = '0;
            end else begin
              used_d = used_q + 1'b1;
            end
          end
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      eng_q  <= '0;
      used_q <= '0;
      len_q  <= '0;
      beat_q <= '0;
      done_q <= 1'b0;
      for (int e = 0; e < NUM_ENG; e++) begin
        sg_q[e]  <= SGI_W'(NUM_SG);
        rem_q[e] <= '0;
        ptr_q[e] <= '0;
      end
    end else begin
      st_q   <= st_d;
      eng_q  <= eng_d;
      used_q <= used_d;
      len_q  <= len_d;
      beat_q <= beat_d;
      done_q <= done_d;
      sg_q   <= sg_d;
      rem_q  <= rem_d;
      ptr_q  <= ptr_d;
    end
  end

  // R2
  req_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> ((req_len != '0) && (int'(req_len) <= BURST)));
  // R10
  req_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready) |=> (req_valid && $stable(req_addr) && $stable(req_len)));
  // R9
  done_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !req_valid);
  // R6
  fin_no_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> !fin[eng_q]);
endmodule

// File: rtl/slot_mem_sched.sv
module slot_mem_sched #(
  parameter int NUM_ENG = 3,
  parameter int NUM_SG  = 2,
  parameter int BURST   = 4,
  parameter int DEPTH   = 8,
  parameter int DATA_W  = 64,
  parameter int SLOT_W  = 4,
  parameter int SIZE_W  = 16,
  parameter int ADDR_W  = 16,
  parameter int LEN_W   = $clog2(BURST + 1)
) (
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic                                  start,
  input  logic [NUM_ENG*NUM_SG-1:0][SLOT_W-1:0] cfg_slots,
  input  logic [NUM_ENG*NUM_SG-1:0][SIZE_W-1:0] cfg_size,
  input  logic [NUM_ENG*NUM_SG-1:0][ADDR_W-1:0] cfg_base,
  output logic                                  req_valid,
  input  logic                                  req_ready,
  output logic [ADDR_W-1:0]                     req_addr,
  output logic [LEN_W-1:0]                      req_len,
  input  logic                                  rd_valid,
  input  logic [DATA_W-1:0]                     rd_data,
  output logic [NUM_ENG-1:0]                    out_valid,
  input  logic [NUM_ENG-1:0]                    out_ready,
  output logic [NUM_ENG*DATA_W-1:0]             out_data,
  output logic                                  done
);
  logic [1:0]         rst_sync_q;
  logic               rst_s;
  logic [NUM_ENG-1:0] push, room;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_s = rst_sync_q[1];

  sms_ctrl #(
    .NUM_ENG(NUM_ENG), .NUM_SG(NUM_SG), .BURST(BURST), .SLOT_W(SLOT_W),
    .SIZE_W(SIZE_W), .ADDR_W(ADDR_W), .LEN_W(LEN_W)
  ) i_ctrl (
    .clk(clk), .rst_n(rst_s), .start(start),
    .cfg_slots(cfg_slots), .cfg_size(cfg_size), .cfg_base(cfg_base),
    .room_i(room), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_len(req_len), .rd_valid(rd_valid),
    .push_o(push), .done(done)
  );

  genvar g;
  generate
    for (g = 0; g < NUM_ENG; g++) begin : g_fifo
      sms_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH), .BURST(BURST)) i_fifo (
        .clk(clk), .rst_n(rst_s), .push_i(push[g]), .din_i(rd_data),
        .ready_i(out_ready[g]), .valid_o(out_valid[g]),
        .dout_o(out_data[g*DATA_W +: DATA_W]), .room_o(room[g])
      );
    end
  endgenerate
endmodule

// File: tb/test_slot_mem_sched.sv
module test_slot_mem_sched;
  localparam int NE = 3;
  localparam int NS = 2;
  localparam int BL = 4;
  localparam int FD = 8;
  localparam int DW = 64;
  localparam int LW = $clog2(BL + 1);

  logic clk = 1'b0;
  logic rst_n, start;
  logic [NE*NS-1:0][3:0]  cfg_slots;
  logic [NE*NS-1:0][15:0] cfg_size;
  logic [NE*NS-1:0][15:0] cfg_base;
  logic req_valid, req_ready, rd_valid, done;
  logic [15:0] req_addr;
  logic [LW-1:0] req_len;
  logic [DW-1:0] rd_data;
  logic [NE-1:0] out_valid, out_ready;
  logic [NE*DW-1:0] out_data;

  always #2 clk = ~clk;

  slot_mem_sched #(.NUM_ENG(NE), .NUM_SG(NS), .BURST(BL), .DEPTH(FD), .DATA_W(DW))
  i_slot_mem_sched (
    .clk(clk), .rst_n(rst_n), .start(start), .cfg_slots(cfg_slots),
    .cfg_size(cfg_size), .cfg_base(cfg_base), .req_valid(req_valid),
    .req_ready(req_ready), .req_addr(req_addr), .req_len(req_len),
    .rd_valid(rd_valid), .rd_data(rd_data), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data), .done(done)
  );

  int vectors = 0, fails = 0, cyc = 0, req_count = 0;
  int sz [NE][NS];
  int sl [NE][NS];
  int m_sg [NE], m_rem [NE], m_ptr [NE], pushed [NE], pops [NE];
  int m_eng, m_used, rdelay;
  bit stall [NE];
  bit prev_wait;
  logic [15:0] prev_addr;
  logic [LW-1:0] prev_len;
  logic [DW-1:0] expq [NE][$];
  int pend [$];

  function automatic logic [DW-1:0] mword(int a);
    return {16'hBEEF, 16'(a), 16'(~a), 16'(a * 7)};
  endfunction

  function automatic int bse(int e, int s);
    return e * 4096 + s * 2048;
  endfunction

  function automatic bit model_fin();
    for (int e = 0; e < NE; e++) if (m_sg[e] < NS) return 1'b0;
    return pend.size() == 0;
  endfunction

  function automatic bit elig(int e);
    if (m_sg[e] >= NS) return 1'b0;
    if (stall[e]) return (pushed[e] - pops[e]) <= FD - BL;
    return 1'b1;
  endfunction

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  endtask

  task automatic take_req();
    int a, l, e, tries, elen;
    a = int'(req_addr);
    l = int'(req_len);
    req_count++;
    for (int i = 0; i < l; i++) pend.push_back(a + i);
    e = m_eng;
    tries = 0;
    while (tries < NE && !elig(e)) begin
      e = (e + 1) % NE;
      m_used = 0;
      tries++;
    end
    if (tries == NE) begin
      chk(1'b0, "R6", "request with no eligible engine", a, 0);
      return;
    end
    m_eng = e;
    elen = (m_rem[e] < BL) ? m_rem[e] : BL;
    chk((a >> 12) == e, "R4", "granted engine", a >> 12, e);
    chk(a == m_ptr[e], "R3", "request address", a, m_ptr[e]);
    chk(l == elen, "R2", "request length", l, elen);
    for (int i = 0; i < l; i++) expq[e].push_back(mword(a + i));
    pushed[e] += l;
    m_ptr[e] += elen;
    m_rem[e] -= elen;
    if (m_rem[e] <= 0) begin
      m_sg[e]++;
      if (m_sg[e] < NS) begin
        m_rem[e] = sz[e][m_sg[e]];
        m_ptr[e] = bse(e, m_sg[e]);
      end
      m_eng = (e + 1) % NE;
      m_used = 0;
    end else begin
      m_used++;
      if (m_used == sl[e][m_sg[e]]) begin
        m_eng = (e + 1) % NE;
        m_used = 0;
      end
    end
  endtask

  // reference model and memory responder, compared every clock
  initial begin
    req_ready = 1'b0;
    rd_valid = 1'b0;
    rd_data = '0;
    out_ready = '0;
    prev_wait = 1'b0;
    rdelay = 0;
    for (int e = 0; e < NE; e++) begin
      m_sg[e] = NS; stall[e] = 1'b0; pushed[e] = 0; pops[e] = 0;
    end
    forever begin
      @(negedge clk);
      cyc++;
      if (cyc > 150000) begin
        fails++;
        $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
        finish_run();
      end
      if (!rst_n) begin
        // R1
        chk(!req_valid && !done && out_valid == '0, "R1", "reset outputs",
            {req_valid, done, out_valid}, 0);
        continue;
      end
      if (prev_wait) begin
        // R10
        chk(req_valid && req_addr == prev_addr && req_len == prev_len, "R10",
            "held request", {req_valid, req_addr}, {1'b1, prev_addr});
      end
      // R9
      chk(!(done && !model_fin()), "R9", "early done", done, 0);
      if (rdelay > 0) begin
        rdelay--;
        rd_valid = 1'b0;
      end else if (pend.size() > 0 && (cyc % 5) != 3) begin
        rd_valid = 1'b1;
        rd_data = mword(pend.pop_front());
      end else begin
        rd_valid = 1'b0;
      end
      req_ready = ((cyc % 3) != 1);
      if (req_valid && req_ready) begin
        take_req();
        rdelay = 2;
      end
      prev_wait = req_valid && !req_ready;
      prev_addr = req_addr;
      prev_len = req_len;
      for (int e = 0; e < NE; e++) begin
        out_ready[e] = !stall[e];
        if (out_valid[e] && out_ready[e]) begin
          logic [DW-1:0] exp_w;
          exp_w = (expq[e].size() > 0) ? expq[e].pop_front() : '0;
          pops[e]++;
          // R8
          chk(out_data[e*DW +: DW] == exp_w, "R8", "engine stream word",
              out_data[e*DW +: DW], exp_w);
        end
      end
    end
  end

  task automatic set_cfg(int s00, int s01, int s10, int s11, int s20, int s21,
                         int l00, int l01, int l10, int l11, int l20, int l21);
    sz[0][0] = s00; sz[0][1] = s01; sz[1][0] = s10;
    sz[1][1] = s11; sz[2][0] = s20; sz[2][1] = s21;
    sl[0][0] = l00; sl[0][1] = l01; sl[1][0] = l10;
    sl[1][1] = l11; sl[2][0] = l20; sl[2][1] = l21;
    for (int e = 0; e < NE; e++)
      for (int s = 0; s < NS; s++) begin
        cfg_size[e*NS+s]  = 16'(sz[e][s]);
        cfg_slots[e*NS+s] = 4'(sl[e][s]);
        cfg_base[e*NS+s]  = 16'(bse(e, s));
      end
  endtask

  task automatic launch();
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    // R9
    chk(done == 1'b0, "R9", "start clears done", done, 0);
    for (int e = 0; e < NE; e++) begin
      m_sg[e] = 0; m_rem[e] = sz[e][0]; m_ptr[e] = bse(e, 0);
      pushed[e] = 0; pops[e] = 0;
    end
    m_eng = 0;
    m_used = 0;
  endtask

  task automatic finish_test();
    while (!(done && model_fin())) @(negedge clk);
    repeat (12) @(negedge clk);
    // R9
    chk(done && !req_valid, "R9", "done held quiet", {done, req_valid}, 2'b10);
    for (int e = 0; e < NE; e++) begin
      // R6
      chk(pushed[e] == sz[e][0] + sz[e][1], "R6", "words granted per engine",
          pushed[e], sz[e][0] + sz[e][1]);
      // R8
      chk(expq[e].size() == 0 && out_valid[e] == 1'b0, "R8", "stream drained",
          expq[e].size(), 0);
    end
  endtask

  initial begin
    int rc;
    rst_n = 1'b0;
    start = 1'b0;
    set_cfg(10, 5, 16, 3, 30, 8, 1, 2, 2, 1, 3, 1);
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    // R1
    chk(!req_valid && !done && out_valid == '0, "R1", "idle before start",
        {req_valid, done, out_valid}, 0);

    // uneven sizes and slot counts, all consumers draining (R2 R3 R4 R5)
    launch();
    finish_test();

    // stalled consumer on engine 0 (R7), restart after done (R9)
    set_cfg(8, 4, 12, 4, 6, 6, 2, 1, 1, 1, 1, 2);
    stall[0] = 1'b1;
    launch();
    while (!(m_sg[1] == NS && m_sg[2] == NS && pend.size() == 0)) @(negedge clk);
    rc = req_count;
    repeat (40) @(negedge clk);
    // R7
    chk(req_count == rc && !req_valid, "R7", "no grant to full FIFO", req_count, rc);
    // R7
    chk(out_valid[0] == 1'b1 && m_sg[0] == 1, "R7", "engine 0 holding data",
        {out_valid[0], 4'(m_sg[0])}, 5'h11);
    // R5
    chk(done == 1'b0, "R5", "unfinished subgraph keeps run open", done, 0);
    stall[0] = 1'b0;
    finish_test();

    // same stream again with all single slots (R4)
    set_cfg(9, 7, 5, 13, 4, 11, 1, 1, 1, 1, 1, 1);
    launch();
    finish_test();

    finish_run();
  end
endmodule